// File: doc/BRIEF.md
# Hit-Map Event Readout Buffer

This block gathers per-event results from 32 channels into a small local buffer that holds up to four events. When an event is accepted, the block stores three things in separate regions: the trigger number, a 32-bit hit map, and one peak word for each channel. A channel counts as hit when its peak word is non-zero.

A host drains the buffer through a plain read port. The current word is always visible on `rdData`, and a one-cycle `rdStrobe` moves to the next word. Each event is read in a fixed order: the trigger-number word, then the hit-map word, then the channel data words in ascending channel order. In compressed mode the block returns only the channels whose hit bit is set. In full mode it returns all 32 channels, zeros included.

The block raises `bufFull` to hold off the trigger system while all four slots are occupied. A synchronous `l1Reset` empties the buffer.

Top module: `hitmap_event_buffer`

## Requirements
- R1: After `rstN` low, or in the cycle after `l1Reset` is high at a clock edge, `rdValid` and `bufFull` are both 0 and no stored event remains.
- R2: An event presented with `evtValid` while the buffer accepts it is stored. Bit i of its hit map is 1 exactly when the peak word of channel i (`evtPeaks[16*i +: 16]`) is non-zero.
- R3: Each event reads out in this order. The first word carries the trigger number in bits 15:0 with the upper bits zero. The second word is the hit map, with bit i for channel i. The data words follow in ascending channel order.
- R4: A data word carries the peak value in bits 15:0 and the channel number in bits 20:16. Bits 31:21 are zero.
- R5: In compressed mode (`fullMode`=0) only the channels with a set hit bit are returned. An event with an all-zero hit map ends after its hit-map word.
- R6: In full mode (`fullMode`=1) all 32 data words are returned, channels with zero peaks included.
- R7: `fullMode` is sampled when the trigger-number word is consumed and holds for the rest of that event. Later changes to `fullMode` do not affect that event.
- R8: `rdLast` is 1 exactly while the final word of the current event is on `rdData`.
- R9: Events read out in arrival order. A `rdStrobe` while `rdValid` is 0 has no effect.
- R10: `bufFull` is 1 while four events are held. An `evtValid` while the buffer is full is dropped, unless the final word of an event is consumed in the same cycle.
- R11: If an event is written in the same cycle that the final word of the head event is consumed, both take effect and the occupancy stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| l1Reset | input | 1 | Synchronous buffer clear |
| evtValid | input | 1 | Event write strobe, one cycle |
| evtTrig | input | 16 | Trigger number of the incoming event |
| evtPeaks | input | 512 | Peak words, channel i at bits 16*i+15 : 16*i |
| fullMode | input | 1 | 1 = read all channels, 0 = hit channels only |
| rdStrobe | input | 1 | Consume the current read word |
| rdData | output | 32 | Current read word |
| rdValid | output | 1 | At least one event is held |
| rdLast | output | 1 | Current word is the last of its event |
| bufFull | output | 1 | All event slots are occupied |

## Verification
The bench targets these corner cases:
- An event whose hit map is all zeros must end on its hit-map word. A design that still emitted a data word for channel 0 would misalign every later event.
- A hit on channel 31 only, or on channel 0 only, exercises the ends of the next-hit search. An off-by-one search would skip the channel or run past the last one.
- Flipping `fullMode` in the middle of an event exposes a design that does not latch the mode per event, because the word count would change.
- A write arriving while the buffer is full and being popped in the same cycle checks that the event is neither lost nor duplicated.
- A write arriving while the buffer is full with no pop checks that it is dropped rather than overwriting the oldest event.

// File: rtl/evbuf_pkg.sv
package evbuf_pkg;
  typedef enum logic [1:0] {PH_TRIG, PH_HIT, PH_DATA} phase_t;

  typedef struct packed {
    logic   push;
    logic   compressed;
    phase_t phase;
  } ctl_t;
endpackage

// File: rtl/evbuf_ctrl.sv
module evbuf_ctrl
  import evbuf_pkg::*;
#(
  parameter int NCH   = 32,
  parameter int DEPTH = 4,
  localparam int CW = $clog2(NCH),
  localparam int SW = $clog2(DEPTH),
  localparam int NW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          l1Reset,
  input  logic          evtValid,
  input  logic          rdStrobe,
  input  logic          fullMode,
  input  logic [NCH-1:0] headHit,
  output ctl_t          ctl,
  output logic [SW-1:0] wrSlot,
  output logic [SW-1:0] rdSlot,
  output logic [CW-1:0] chIdx,
  output logic          rdValid,
  output logic          rdLast,
  output logic          bufFull
);
  logic [NW-1:0] count;
  logic [SW-1:0] wrPtr, rdPtr;
  phase_t        phase;
  logic          compLat;
  logic          useComp, found, advance, pop, push;
  logic [NCH-1:0] mask;
  logic [CW-1:0] nextCh;

  function automatic logic [SW-1:0] incPtr(input logic [SW-1:0] p);
    return (p == SW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign bufFull = (count == NW'(DEPTH));
  assign rdValid = (count != '0);
  assign useComp = (phase == PH_TRIG) ? !fullMode : compLat;
  assign mask    = useComp ? headHit : '1;

  always_comb begin
    found  = 1'b0;
    nextCh = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (mask[i] && (phase != PH_DATA || i > int'(chIdx))) begin
        found  = 1'b1;
        nextCh = CW'(i);
      end
    end
  end

  assign rdLast  = (phase != PH_TRIG) && !found;
  assign advance = rdValid && rdStrobe;
  assign pop     = advance && rdLast;
  assign push    = evtValid && (!bufFull || pop);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count   <= '0;
      wrPtr   <= '0;
      rdPtr   <= '0;
      phase   <= PH_TRIG;
      chIdx   <= '0;
      compLat <= 1'b0;
    end else if (l1Reset) begin
      count   <= '0;
      wrPtr   <= '0;
      rdPtr   <= '0;
      phase   <= PH_TRIG;
      chIdx   <= '0;
      compLat <= 1'b0;
    end else begin
      if (push) wrPtr <= incPtr(wrPtr);
      if (advance) begin
        if (phase == PH_TRIG) begin
          phase   <= PH_HIT;
          compLat <= !fullMode;
        end else if (found) begin
          phase <= PH_DATA;
          chIdx <= nextCh;
        end else begin
          phase <= PH_TRIG;
          chIdx <= '0;
          rdPtr <= incPtr(rdPtr);
        end
      end
      count <= count + NW'(push) - NW'(pop);
    end
  end

  assign wrSlot         = wrPtr;
  assign rdSlot         = rdPtr;
  assign ctl.push       = push;
  assign ctl.compressed = compLat;
  assign ctl.phase      = phase;

  // R1
  clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    l1Reset |=> (!rdValid && !bufFull));
  // R10
  full_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!l1Reset && bufFull && !(rdStrobe && rdLast)) |=> bufFull);
  // R11
  pushpop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!l1Reset && rdValid && rdStrobe && rdLast && evtValid) |=> $stable(count));
  // R9
  idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!l1Reset && !rdValid && !evtValid) |=> (!rdValid && $stable(phase)));
endmodule

// File: rtl/evbuf_dpath.sv
module evbuf_dpath
  import evbuf_pkg::*;
#(
  parameter int NCH   = 32,
  parameter int DEPTH = 4,
  parameter int PW    = 16,
  parameter int TW    = 16,
  localparam int CW = $clog2(NCH),
  localparam int SW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctl_t              ctl,
  input  logic [SW-1:0]     wrSlot,
  input  logic [SW-1:0]     rdSlot,
  input  logic [CW-1:0]     chIdx,
  input  logic              rdValid,
  input  logic [TW-1:0]     evtTrig,
  input  logic [NCH*PW-1:0] evtPeaks,
  output logic [NCH-1:0]    headHit,
  output logic [NCH-1:0]    rdData
);
  logic [TW-1:0]  trigMem [DEPTH];
  logic [NCH-1:0] hitMem  [DEPTH];
  logic [PW-1:0]  dataMem [DEPTH][NCH];
  logic [NCH-1:0] newHit;

  always_comb begin
    for (int i = 0; i < NCH; i++) newHit[i] = |evtPeaks[i*PW +: PW];
  end

  always_ff @(posedge clk) begin
    if (ctl.push) begin
      trigMem[wrSlot] <= evtTrig;
      hitMem[wrSlot]  <= newHit;
      for (int i = 0; i < NCH; i++) dataMem[wrSlot][i] <= evtPeaks[i*PW +: PW];
    end
  end

  assign headHit = hitMem[rdSlot];

  always_comb begin
    case (ctl.phase)
      PH_TRIG: rdData = NCH'(trigMem[rdSlot]);
      PH_HIT:  rdData = hitMem[rdSlot];
      default: rdData = NCH'({chIdx, dataMem[rdSlot][chIdx]});
    endcase
  end

  // R5
  data_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && ctl.phase == PH_DATA && ctl.compressed) |-> headHit[chIdx]);
endmodule

// File: rtl/hitmap_event_buffer.sv
module hitmap_event_buffer
  import evbuf_pkg::*;
#(
  parameter int NCH   = 32,
  parameter int DEPTH = 4,
  parameter int PW    = 16,
  parameter int TW    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              l1Reset,
  input  logic              evtValid,
  input  logic [TW-1:0]     evtTrig,
  input  logic [NCH*PW-1:0] evtPeaks,
  input  logic              fullMode,
  input  logic              rdStrobe,
  output logic [NCH-1:0]    rdData,
  output logic              rdValid,
  output logic              rdLast,
  output logic              bufFull
);
  localparam int CW = $clog2(NCH);
  localparam int SW = $clog2(DEPTH);

  ctl_t           ctl;
  logic [SW-1:0]  wrSlot, rdSlot;
  logic [CW-1:0]  chIdx;
  logic [NCH-1:0] headHit;

  evbuf_ctrl #(.NCH(NCH), .DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .l1Reset(l1Reset), .evtValid(evtValid),
    .rdStrobe(rdStrobe), .fullMode(fullMode), .headHit(headHit),
    .ctl(ctl), .wrSlot(wrSlot), .rdSlot(rdSlot), .chIdx(chIdx),
    .rdValid(rdValid), .rdLast(rdLast), .bufFull(bufFull)
  );

  evbuf_dpath #(.NCH(NCH), .DEPTH(DEPTH), .PW(PW), .TW(TW)) u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrSlot(wrSlot), .rdSlot(rdSlot),
    .chIdx(chIdx), .rdValid(rdValid), .evtTrig(evtTrig), .evtPeaks(evtPeaks),
    .headHit(headHit), .rdData(rdData)
  );
endmodule

// File: tb/tb_hitmap_event_buffer.sv
module tb_hitmap_event_buffer;
  localparam int NCH = 32;
  localparam int PW  = 16;

  logic clk = 0, rstN = 0, l1Reset = 0, evtValid = 0, fullMode = 0, rdStrobe = 0;
  logic [15:0] evtTrig = '0;
  logic [NCH*PW-1:0] evtPeaks = '0;
  logic [31:0] rdData;
  logic rdValid, rdLast, bufFull;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  hitmap_event_buffer dut (
    .clk(clk), .rstN(rstN), .l1Reset(l1Reset), .evtValid(evtValid),
    .evtTrig(evtTrig), .evtPeaks(evtPeaks), .fullMode(fullMode),
    .rdStrobe(rdStrobe), .rdData(rdData), .rdValid(rdValid),
    .rdLast(rdLast), .bufFull(bufFull)
  );

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [NCH*PW-1:0] mkPeaks(input int seed, input logic [NCH-1:0] m);
    logic [NCH*PW-1:0] p = '0;
    for (int i = 0; i < NCH; i++)
      if (m[i]) p[i*PW +: PW] = 16'h8000 | 16'((seed * 256 + i * 7) & 16'h7fff);
    return p;
  endfunction

  task automatic pushEvt(input logic [15:0] t, input logic [NCH*PW-1:0] p);
    @(negedge clk);
    evtTrig = t; evtPeaks = p; evtValid = 1;
    @(negedge clk);
    evtValid = 0;
  endtask

  // Reads one event, comparing every word against the expected stream.
  task automatic readEvt(input logic [15:0] t, input logic [NCH*PW-1:0] p,
                         input logic mode, input logic flip, input string req);
    logic [31:0] expw [0:33];
    logic [31:0] hm = '0;
    int n = 2;
    for (int i = 0; i < NCH; i++) hm[i] = (p[i*PW +: PW] != 0);
    expw[0] = {16'h0, t};
    expw[1] = hm;
    for (int i = 0; i < NCH; i++)
      if (mode || hm[i]) begin
        expw[n] = {11'h0, 5'(i), p[i*PW +: PW]};
        n++;
      end
    @(negedge clk);
    fullMode = mode;
    for (int k = 0; k < n; k++) begin
      #1;
      chk(rdValid, req, 32'(rdValid), 1);
      chk(rdData == expw[k], req, rdData, expw[k]);
      chk(rdLast == (k == n - 1), {req, " R8"}, 32'(rdLast), 32'(k == n - 1));
      rdStrobe = 1;
      @(negedge clk);
      rdStrobe = 0;
      if (k == 0 && flip) fullMode = !mode;
    end
  endtask

  task automatic testReset;
    #1;
    chk(!rdValid && !bufFull, "R1 reset", {rdValid, bufFull}, 0);
  endtask

  task automatic testCompressed;
    // R2 R3 R4 R5: sparse hits including both end channels
    logic [NCH*PW-1:0] p = mkPeaks(3, 32'h8000_1021);
    pushEvt(16'h1234, p);
    readEvt(16'h1234, p, 0, 0, "R5 compressed");
    p = mkPeaks(5, 32'h8000_0000);
    pushEvt(16'hbeef, p);
    readEvt(16'hbeef, p, 0, 0, "R3 only ch31");
    p = mkPeaks(6, 32'h0000_0001);
    pushEvt(16'h0001, p);
    readEvt(16'h0001, p, 0, 0, "R4 only ch0");
  endtask

  task automatic testFull;
    logic [NCH*PW-1:0] p = mkPeaks(9, 32'h0f0f_00a5);
    pushEvt(16'h00aa, p);
    readEvt(16'h00aa, p, 1, 0, "R6 full");
  endtask

  task automatic testEmptyMap;
    pushEvt(16'h0777, '0);
    readEvt(16'h0777, '0, 0, 0, "R5 empty map");
    #1 chk(!rdValid, "R5 empty drained", 32'(rdValid), 0);
  endtask

  task automatic testModeLatch;
    logic [NCH*PW-1:0] p = mkPeaks(11, 32'h0000_0300);
    pushEvt(16'h5151, p);
    readEvt(16'h5151, p, 0, 1, "R7 comp->full");
    pushEvt(16'h5252, p);
    readEvt(16'h5252, p, 1, 1, "R7 full->comp");
  endtask

  task automatic testIdleStrobe;
    logic [NCH*PW-1:0] p = mkPeaks(13, 32'h0000_0010);
    @(negedge clk);
    rdStrobe = 1;
    @(negedge clk);
    rdStrobe = 0;
    #1 chk(!rdValid, "R9 idle strobe", 32'(rdValid), 0);
    pushEvt(16'h0909, p);
    readEvt(16'h0909, p, 0, 0, "R9 after idle strobe");
  endtask

  task automatic testFullDrop;
    // R10 and R11: fill, drop an extra write, then push during the last-word pop
    for (int e = 0; e < 4; e++) begin
      #1 chk(!bufFull, "R10 not full yet", 32'(bufFull), 0);
      pushEvt(16'(16'h0100 + e), (e == 0) ? '0 : mkPeaks(20 + e, 32'h0000_0006 << e));
    end
    #1 chk(bufFull, "R10 full", 32'(bufFull), 1);
    pushEvt(16'hdead, mkPeaks(30, 32'hffff_ffff));
    #1 chk(bufFull, "R10 still full", 32'(bufFull), 1);
    // head event has an empty map: trig word then hit map word (last)
    @(negedge clk);
    fullMode = 0;
    #1 chk(rdData == 32'h0100, "R10 head kept", rdData, 32'h0100);
    rdStrobe = 1;
    @(negedge clk);
    #1 chk(rdLast, "R11 last word", 32'(rdLast), 1);
    evtTrig = 16'h0200; evtPeaks = mkPeaks(40, 32'h4000_0000); evtValid = 1;
    @(negedge clk);
    rdStrobe = 0; evtValid = 0;
    #1 chk(bufFull, "R11 occupancy held", 32'(bufFull), 1);
    for (int e = 1; e < 4; e++)
      readEvt(16'(16'h0100 + e), mkPeaks(20 + e, 32'h0000_0006 << e), 0, 0, "R9 order");
    readEvt(16'h0200, mkPeaks(40, 32'h4000_0000), 0, 0, "R11 new event");
    #1 chk(!rdValid, "R10 dropped write", 32'(rdValid), 0);
  endtask

  task automatic testL1Reset;
    pushEvt(16'h3333, mkPeaks(50, 32'h1));
    pushEvt(16'h3334, mkPeaks(51, 32'h2));
    @(negedge clk);
    l1Reset = 1;
    @(negedge clk);
    l1Reset = 0;
    #1 chk(!rdValid && !bufFull, "R1 l1Reset", {rdValid, bufFull}, 0);
    pushEvt(16'h4444, mkPeaks(52, 32'h4));
    readEvt(16'h4444, mkPeaks(52, 32'h4), 0, 0, "R1 after clear");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    testReset();
    testCompressed();
    testFull();
    testEmptyMap();
    testModeLatch();
    testIdleStrobe();
    testFullDrop();
    testL1Reset();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule